// File: doc/BRIEF.md
# Command Decoder and Page Controller

This block sits behind a serial slave front end that has already turned bus traffic into whole bytes. Each byte arrives with a strobe and a flag that marks it as a command code or as payload. The block acts only on command codes in the range 94h to 9Bh. It keeps track of which address space later transfers refer to: the default register page, the extended page, or the nonvolatile page. It also remembers whether the last transfer command was a block write or a block read.

Two commands start longer operations. A reboot command does the same work as a power-on reset: it returns the page and transfer mode to their reset values, then copies a window of configuration bytes from nonvolatile storage into the same addresses of the register file. Each nonvolatile read in that copy must be primed, so every byte takes a fixed sequence of steps. A fault-store command reads the fault-log control register in the register file and raises a request that carries the selection bits from that register. The request holds until the storage side acknowledges it.

While either operation runs, a busy flag is high and every command is refused. Codes outside the command range are flagged and have no other effect.

Top module: `cmdpg_ctrl`

## Requirements
- R1: While reset is held (synchronous, active low), page_sel reads 0 (default page), xfer_mode reads 0 (none), busy reads 1, and cmd_invalid, cmd_reject and fault_req read 0.
- R2: After reset is released, every register-file address from 0Fh to 7Dh receives the nonvolatile byte at the same address, and no other address is written. Busy falls exactly 5 clock edges per copied address after release (555 edges with the default window).
- R3: Each copied byte follows a fixed order, one step per cycle: load address, dummy read, load the same address again, read, then register-file write. The write data is the byte returned by the second read.
- R4: Page encoding is 0 default, 1 extended, 2 nonvolatile. Code 98h selects 1, 9Ah selects 2, and both 99h and 9Bh select 0. The new page is visible in the cycle after the strobe edge and persists until another page command or a reboot.
- R5: Transfer-mode encoding is 0 none, 1 block write, 2 block read. Code 94h selects 1 and 95h selects 2. Codes 97h to 9Bh leave the mode unchanged.
- R6: Code 96h sets page_sel and xfer_mode to 0 and reruns the copy of R2 and R3. Busy is high from the cycle after the strobe edge and falls 1 + 5 edges per address after that edge.
- R7: Code 97h raises busy in the cycle after the strobe edge. One cycle later fault_req rises with fault_sel equal to the low bits of register 47h. fault_req holds until fault_done is sampled high, and busy and fault_req both fall in the next cycle.
- R8: A command byte outside 94h to 9Bh, sent while idle, pulses cmd_invalid for exactly one cycle and leaves page, mode and busy unchanged.
- R9: Any command byte sent while busy pulses cmd_reject for one cycle, does not pulse cmd_invalid, and changes neither page nor mode.
- R10: A byte whose command flag is low changes no output, even when its value equals a command code.
- R11: Register-file writes and fault_req occur only while busy is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| byte_vld | input | 1 | Byte strobe, one cycle per byte |
| byte_is_cmd | input | 1 | High when the strobed byte is a command code |
| byte_data | input | 8 | Strobed byte |
| page_sel | output | 2 | Active address space: 0 default, 1 extended, 2 nonvolatile |
| xfer_mode | output | 2 | Transfer mode: 0 none, 1 block write, 2 block read |
| busy | output | 1 | Copy or fault store in progress |
| cmd_invalid | output | 1 | One-cycle pulse for an unknown command code |
| cmd_reject | output | 1 | One-cycle pulse for a command received while busy |
| ee_addr | output | ADDR_W | Nonvolatile address |
| ee_set | output | 1 | Load ee_addr into the nonvolatile pointer |
| ee_rd | output | 1 | Nonvolatile read strobe; data appears on ee_rdata the next cycle |
| ee_rdata | input | DATA_W | Nonvolatile read data |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | ADDR_W | Register-file write address |
| rf_wdata | output | DATA_W | Register-file write data |
| rf_raddr | output | ADDR_W | Register-file read address (fault-log control register) |
| rf_rdata | input | DATA_W | Register-file read data, combinational |
| fault_req | output | 1 | Fault-store request |
| fault_sel | output | SEL_W | Store selection taken from the control register |
| fault_done | input | 1 | Fault-store completion |

## Verification
Page, mode and both flags are due in the cycle after the edge that samples the strobe. The bench drives each byte on a falling edge and reads those outputs on the next falling edge, so exactly one register lies between stimulus and check. fault_req is due one cycle later than busy, because the control register is read in between. Busy after reset or a reboot is timed by counting rising edges until it falls and comparing the count with five edges per address (plus the strobe edge for a reboot). Copy contents are checked byte by byte against a nonvolatile model that returns wrong data unless the priming order was followed. The command sweep covers all 256 codes.

// File: rtl/cmdpg_pkg.sv
// Package: shared encodings for the command decoder and page controller.
// Assumes 8-bit command codes; page and mode encodings are visible at the ports.
package cmdpg_pkg;

    typedef enum logic [1:0] {
        PG_DEFAULT  = 2'd0,
        PG_EXTENDED = 2'd1,
        PG_NVM      = 2'd2
    } page_e;

    typedef enum logic [1:0] {
        XF_NONE     = 2'd0,
        XF_BLOCK_WR = 2'd1,
        XF_BLOCK_RD = 2'd2
    } xfer_e;

    localparam logic [7:0] OP_BLOCK_WR = 8'h94;
    localparam logic [7:0] OP_BLOCK_RD = 8'h95;
    localparam logic [7:0] OP_REBOOT   = 8'h96;
    localparam logic [7:0] OP_FAULT    = 8'h97;
    localparam logic [7:0] OP_EXT_ON   = 8'h98;
    localparam logic [7:0] OP_EXT_OFF  = 8'h99;
    localparam logic [7:0] OP_NVM_ON   = 8'h9A;
    localparam logic [7:0] OP_NVM_OFF  = 8'h9B;

    // One decoded action per strobed byte
    typedef struct packed {
        logic  invalid;
        logic  reject;
        logic  set_page;
        page_e page;
        logic  set_xfer;
        xfer_e xfer;
        logic  reboot;
        logic  fault;
    } action_t;

endpackage

// File: rtl/cmdpg_decode.sv
// Module: cmdpg_decode
// Turns one strobed command byte into an action. Purely combinational.
// Assumes the caller registers the result; payload bytes produce no action.
module cmdpg_decode
    import cmdpg_pkg::*;
(
    input  logic       byte_vld,
    input  logic       byte_is_cmd,
    input  logic [7:0] byte_data,
    input  logic       busy,
    output action_t    act
);

    // Map the code to an action, refusing everything while busy
    always_comb begin
        act = '0;
        if (byte_vld && byte_is_cmd) begin
            if (busy) begin
                act.reject = 1'b1;
            end else begin
                case (byte_data)
                    OP_BLOCK_WR: begin
                        act.set_xfer = 1'b1;
                        act.xfer     = XF_BLOCK_WR;
                    end
                    OP_BLOCK_RD: begin
                        act.set_xfer = 1'b1;
                        act.xfer     = XF_BLOCK_RD;
                    end
                    OP_REBOOT: begin
                        act.reboot   = 1'b1;
                        act.set_page = 1'b1;
                        act.page     = PG_DEFAULT;
                        act.set_xfer = 1'b1;
                        act.xfer     = XF_NONE;
                    end
                    OP_FAULT: begin
                        act.fault = 1'b1;
                    end
                    OP_EXT_ON: begin
                        act.set_page = 1'b1;
                        act.page     = PG_EXTENDED;
                    end
                    OP_NVM_ON: begin
                        act.set_page = 1'b1;
                        act.page     = PG_NVM;
                    end
                    OP_EXT_OFF, OP_NVM_OFF: begin
                        act.set_page = 1'b1;
                        act.page     = PG_DEFAULT;
                    end
                    default: begin
                        act.invalid = 1'b1;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/cmdpg_copy_engine.sv
// Module: cmdpg_copy_engine
// Copies nonvolatile bytes COPY_LO..COPY_HI into the register file at the
// same addresses. Each byte is primed: load address, dummy read, load again,
// read, write. Assumes the nonvolatile side returns data one cycle after a
// read strobe. Reset leaves the engine armed, so a copy follows every reset.
module cmdpg_copy_engine #(
    parameter int              ADDR_W  = 8,
    parameter int              DATA_W  = 8,
    parameter logic [ADDR_W-1:0] COPY_LO = 8'h0F,
    parameter logic [ADDR_W-1:0] COPY_HI = 8'h7D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic [ADDR_W-1:0] ee_addr,
    output logic              ee_set,
    output logic              ee_rd,
    input  logic [DATA_W-1:0] ee_rdata,
    output logic              rf_we,
    output logic [ADDR_W-1:0] rf_waddr,
    output logic [DATA_W-1:0] rf_wdata
);

    localparam logic [ADDR_W-1:0] ADDR_ONE = 1;

    typedef enum logic [2:0] {
        E_IDLE, E_LOAD1, E_DUMMY, E_LOAD2, E_READ, E_WRITE
    } eng_e;

    eng_e              state_q;
    logic [ADDR_W-1:0] addr_q;

    // Step through the five-cycle primed copy for each address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= E_LOAD1;
            addr_q  <= COPY_LO;
        end else begin
            case (state_q)
                E_IDLE: begin
                    if (start) begin
                        state_q <= E_LOAD1;
                        addr_q  <= COPY_LO;
                    end
                end
                E_LOAD1: state_q <= E_DUMMY;
                E_DUMMY: state_q <= E_LOAD2;
                E_LOAD2: state_q <= E_READ;
                E_READ:  state_q <= E_WRITE;
                E_WRITE: begin
                    if (addr_q == COPY_HI) begin
                        state_q <= E_IDLE;
                    end else begin
                        state_q <= E_LOAD1;
                        addr_q  <= addr_q + ADDR_ONE;
                    end
                end
                default: state_q <= E_IDLE;
            endcase
        end
    end

    // Drive the strobes from the current step
    always_comb begin
        busy     = (state_q != E_IDLE);
        ee_addr  = addr_q;
        ee_set   = (state_q == E_LOAD1) || (state_q == E_LOAD2);
        ee_rd    = (state_q == E_DUMMY) || (state_q == E_READ);
        rf_we    = (state_q == E_WRITE);
        rf_waddr = addr_q;
        rf_wdata = ee_rdata;
    end

endmodule

// File: rtl/cmdpg_fault_seq.sv
// Module: cmdpg_fault_seq
// Reads the fault-log control register, then holds a store request carrying
// its selection bits until the storage side reports completion.
// Assumes the register-file read port is combinational.
module cmdpg_fault_seq #(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 8,
    parameter int                SEL_W     = 2,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h47
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              done,
    output logic              busy,
    output logic [ADDR_W-1:0] rf_raddr,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              req,
    output logic [SEL_W-1:0]  sel
);

    typedef enum logic [1:0] { F_IDLE, F_READ, F_REQ } flt_e;

    flt_e             state_q;
    logic [SEL_W-1:0] sel_q;
    logic             unused_rdata;

    // Sequence: capture control bits, then wait for completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= F_IDLE;
            sel_q   <= '0;
        end else begin
            case (state_q)
                F_IDLE: if (start) state_q <= F_READ;
                F_READ: begin
                    sel_q   <= rf_rdata[SEL_W-1:0];
                    state_q <= F_REQ;
                end
                F_REQ:  if (done) state_q <= F_IDLE;
                default: state_q <= F_IDLE;
            endcase
        end
    end

    // Outputs follow the state
    always_comb begin
        busy         = (state_q != F_IDLE);
        req          = (state_q == F_REQ);
        sel          = sel_q;
        rf_raddr     = CTRL_ADDR;
        unused_rdata = ^rf_rdata;
    end

endmodule

// File: rtl/cmdpg_ctrl.sv
// Module: cmdpg_ctrl (top)
// Command decoder and page controller. Acts on command bytes 94h..9Bh,
// keeps the active page and transfer mode, and runs the boot copy and the
// fault store. Assumes one byte strobe at most per cycle; busy refuses commands.
module cmdpg_ctrl
    import cmdpg_pkg::*;
#(
    parameter int                ADDR_W          = 8,
    parameter int                DATA_W          = 8,
    parameter int                SEL_W           = 2,
    parameter logic [ADDR_W-1:0] COPY_LO         = 8'h0F,
    parameter logic [ADDR_W-1:0] COPY_HI         = 8'h7D,
    parameter logic [ADDR_W-1:0] FAULT_CTRL_ADDR = 8'h47
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic              byte_is_cmd,
    input  logic [7:0]        byte_data,
    output logic [1:0]        page_sel,
    output logic [1:0]        xfer_mode,
    output logic              busy,
    output logic              cmd_invalid,
    output logic              cmd_reject,
    output logic [ADDR_W-1:0] ee_addr,
    output logic              ee_set,
    output logic              ee_rd,
    input  logic [DATA_W-1:0] ee_rdata,
    output logic              rf_we,
    output logic [ADDR_W-1:0] rf_waddr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic [ADDR_W-1:0] rf_raddr,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              fault_req,
    output logic [SEL_W-1:0]  fault_sel,
    input  logic              fault_done
);

    action_t act;
    page_e   page_q;
    xfer_e   xfer_q;
    logic    invalid_q;
    logic    reject_q;
    logic    copy_busy;
    logic    fault_busy;

    cmdpg_decode u_decode (
        .byte_vld    (byte_vld),
        .byte_is_cmd (byte_is_cmd),
        .byte_data   (byte_data),
        .busy        (busy),
        .act         (act)
    );

    cmdpg_copy_engine #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .COPY_LO (COPY_LO),
        .COPY_HI (COPY_HI)
    ) u_copy (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (act.reboot),
        .busy     (copy_busy),
        .ee_addr  (ee_addr),
        .ee_set   (ee_set),
        .ee_rd    (ee_rd),
        .ee_rdata (ee_rdata),
        .rf_we    (rf_we),
        .rf_waddr (rf_waddr),
        .rf_wdata (rf_wdata)
    );

    cmdpg_fault_seq #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .SEL_W     (SEL_W),
        .CTRL_ADDR (FAULT_CTRL_ADDR)
    ) u_fault (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (act.fault),
        .done     (fault_done),
        .busy     (fault_busy),
        .rf_raddr (rf_raddr),
        .rf_rdata (rf_rdata),
        .req      (fault_req),
        .sel      (fault_sel)
    );

    // Hold the active page and transfer mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= PG_DEFAULT;
            xfer_q <= XF_NONE;
        end else begin
            if (act.set_page) page_q <= act.page;
            if (act.set_xfer) xfer_q <= act.xfer;
        end
    end

    // Register the one-cycle status pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            invalid_q <= 1'b0;
            reject_q  <= 1'b0;
        end else begin
            invalid_q <= act.invalid;
            reject_q  <= act.reject;
        end
    end

    // Drive the outputs
    always_comb begin
        busy        = copy_busy | fault_busy;
        page_sel    = page_q;
        xfer_mode   = xfer_q;
        cmd_invalid = invalid_q;
        cmd_reject  = reject_q;
    end

endmodule

// File: rtl/cmdpg_ctrl_chk.sv
// Module: cmdpg_ctrl_chk
// Property checker for cmdpg_ctrl, attached by bind below. Observes ports only.
module cmdpg_ctrl_chk #(
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] COPY_LO = 8'h0F,
    parameter logic [ADDR_W-1:0] COPY_HI = 8'h7D
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        page_sel,
    input logic [1:0]        xfer_mode,
    input logic              busy,
    input logic              cmd_invalid,
    input logic              cmd_reject,
    input logic              ee_set,
    input logic              ee_rd,
    input logic              rf_we,
    input logic [ADDR_W-1:0] rf_waddr,
    input logic              fault_req,
    input logic              fault_done
);

    AST_RESET_STATE: assert property (@(posedge clk) !rst_n |=> (page_sel == 2'd0 && xfer_mode == 2'd0 && !fault_req && !cmd_invalid && !cmd_reject)); // R1
    AST_WRITE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) rf_we |-> (rf_waddr >= COPY_LO && rf_waddr <= COPY_HI)); // R2
    AST_READ_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n) ee_rd |-> $past(ee_set)); // R3
    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n) rf_we |-> $past(ee_rd)); // R3
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (fault_req && !fault_done) |=> fault_req); // R7
    AST_INVALID_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) cmd_invalid |-> ($stable(page_sel) && $stable(xfer_mode))); // R8
    AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) cmd_reject |-> ($stable(page_sel) && $stable(xfer_mode))); // R9
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(cmd_invalid && cmd_reject)); // R9
    AST_WRITE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) rf_we |-> busy); // R11
    AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n) fault_req |-> busy); // R11

endmodule

bind cmdpg_ctrl cmdpg_ctrl_chk #(
    .ADDR_W  (ADDR_W),
    .COPY_LO (COPY_LO),
    .COPY_HI (COPY_HI)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .page_sel    (page_sel),
    .xfer_mode   (xfer_mode),
    .busy        (busy),
    .cmd_invalid (cmd_invalid),
    .cmd_reject  (cmd_reject),
    .ee_set      (ee_set),
    .ee_rd       (ee_rd),
    .rf_we       (rf_we),
    .rf_waddr    (rf_waddr),
    .fault_req   (fault_req),
    .fault_done  (fault_done)
);

// File: tb/cmdpg_ctrl_test.sv
// Bench for cmdpg_ctrl: sweeps every command code and checks boot copy,
// reboot, fault store, refusal while busy and payload bytes.
module cmdpg_ctrl_test;

    localparam int LO      = 8'h0F;
    localparam int HI      = 8'h7D;
    localparam int N_COPY  = HI - LO + 1;
    localparam logic [7:0] FILL = 8'hC3;
    localparam logic [7:0] JUNK = 8'hA5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_vld = 1'b0;
    logic       byte_is_cmd = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic [1:0] page_sel;
    logic [1:0] xfer_mode;
    logic       busy;
    logic       cmd_invalid;
    logic       cmd_reject;
    logic [7:0] ee_addr;
    logic       ee_set;
    logic       ee_rd;
    logic [7:0] ee_rdata;
    logic       rf_we;
    logic [7:0] rf_waddr;
    logic [7:0] rf_wdata;
    logic [7:0] rf_raddr;
    logic [7:0] rf_rdata;
    logic       fault_req;
    logic [1:0] fault_sel;
    logic       fault_done = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    cmdpg_ctrl uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_vld    (byte_vld),
        .byte_is_cmd (byte_is_cmd),
        .byte_data   (byte_data),
        .page_sel    (page_sel),
        .xfer_mode   (xfer_mode),
        .busy        (busy),
        .cmd_invalid (cmd_invalid),
        .cmd_reject  (cmd_reject),
        .ee_addr     (ee_addr),
        .ee_set      (ee_set),
        .ee_rd       (ee_rd),
        .ee_rdata    (ee_rdata),
        .rf_we       (rf_we),
        .rf_waddr    (rf_waddr),
        .rf_wdata    (rf_wdata),
        .rf_raddr    (rf_raddr),
        .rf_rdata    (rf_rdata),
        .fault_req   (fault_req),
        .fault_sel   (fault_sel),
        .fault_done  (fault_done)
    );

    // Nonvolatile model: contents are addr ^ seed, valid only after priming
    logic [7:0] ee_seed  = 8'h5A;
    logic [1:0] ee_stage = 2'd0;
    logic [7:0] ee_ptr   = 8'h00;
    logic [7:0] ee_q     = 8'h00;
    always @(posedge clk) begin
        if (ee_set) begin
            ee_stage <= (ee_stage == 2'd2 && ee_addr == ee_ptr) ? 2'd3 : 2'd1;
            ee_ptr   <= ee_addr;
        end else if (ee_rd) begin
            if (ee_stage == 2'd3) begin
                ee_q     <= ee_ptr ^ ee_seed;
                ee_stage <= 2'd0;
            end else begin
                ee_q     <= JUNK;
                ee_stage <= (ee_stage == 2'd1) ? 2'd2 : 2'd0;
            end
        end
    end
    assign ee_rdata = ee_q;

    // Register-file model with a bench write port and a fill strobe
    logic [7:0] rf_mem [256];
    logic       tb_fill = 1'b0;
    logic       tb_we = 1'b0;
    logic [7:0] tb_waddr = 8'h00;
    logic [7:0] tb_wdata = 8'h00;
    always @(posedge clk) begin
        if (tb_fill) begin
            for (int i = 0; i < 256; i++) rf_mem[i] <= FILL;
        end else if (rf_we) begin
            rf_mem[rf_waddr] <= rf_wdata;
        end else if (tb_we) begin
            rf_mem[tb_waddr] <= tb_wdata;
        end
    end
    assign rf_rdata = rf_mem[rf_raddr];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act_v, input logic [31:0] exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act_v, exp_v);
        end
    endtask

    task automatic chk_eq(input string req, input string what,
                          input logic [31:0] act_v, input logic [31:0] exp_v);
        check(act_v == exp_v, req, what, act_v, exp_v);
    endtask

    // Called just after a falling edge; returns just after the next one
    task automatic send_byte(input logic is_cmd, input logic [7:0] d);
        byte_vld    = 1'b1;
        byte_is_cmd = is_cmd;
        byte_data   = d;
        @(posedge clk);
        @(negedge clk);
        byte_vld    = 1'b0;
        byte_is_cmd = 1'b0;
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 5000) begin
            @(posedge clk);
            @(negedge clk);
            n++;
        end
    endtask

    task automatic tb_rf_write(input logic [7:0] a, input logic [7:0] d);
        tb_we = 1'b1; tb_waddr = a; tb_wdata = d;
        @(posedge clk);
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic verify_copy(input string req);
        for (int a = 0; a < 256; a++) begin
            logic [7:0] e;
            e = (a >= LO && a <= HI) ? (8'(a) ^ ee_seed) : FILL;
            chk_eq(req, $sformatf("rf[%0h]", a), 32'(rf_mem[a]), 32'(e));
        end
    endtask

    // Watchdog: a hung run is one failed check and still reports
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n;
        logic [1:0] exp_page;
        logic [1:0] exp_xfer;
        @(negedge clk);
        tb_fill = 1'b1;
        step(1);
        tb_fill = 1'b0;
        step(2);
        // R1: reset state
        chk_eq("R1", "page", 32'(page_sel), 0);
        chk_eq("R1", "xfer", 32'(xfer_mode), 0);
        chk_eq("R1", "busy", 32'(busy), 1);
        chk_eq("R1", "invalid", 32'(cmd_invalid), 0);
        chk_eq("R1", "reject", 32'(cmd_reject), 0);
        chk_eq("R1", "fault_req", 32'(fault_req), 0);
        chk_eq("R1", "rf untouched", 32'(rf_mem[LO]), 32'(FILL));
        rst_n = 1'b1;

        // R9: commands during the boot copy are refused
        send_byte(1'b1, 8'h98);
        chk_eq("R9", "reject boot", 32'(cmd_reject), 1);
        chk_eq("R9", "page boot", 32'(page_sel), 0);
        send_byte(1'b1, 8'h00);
        chk_eq("R9", "reject unknown", 32'(cmd_reject), 1);
        chk_eq("R9", "no invalid", 32'(cmd_invalid), 0);
        // R2: busy falls 5 edges per address after release
        wait_idle(n);
        chk_eq("R2", "boot edges", 32'(n + 2), 32'(5 * N_COPY));
        verify_copy("R2/R3");

        // R10: payload bytes equal to command codes do nothing
        send_byte(1'b0, 8'h9A);
        chk_eq("R10", "page", 32'(page_sel), 0);
        chk_eq("R10", "invalid", 32'(cmd_invalid), 0);
        send_byte(1'b0, 8'h96);
        chk_eq("R10", "busy", 32'(busy), 0);
        send_byte(1'b0, 8'h00);
        chk_eq("R10", "invalid", 32'(cmd_invalid), 0);
        chk_eq("R10", "reject", 32'(cmd_reject), 0);

        // R8: invalid pulse lasts one cycle
        send_byte(1'b1, 8'h10);
        chk_eq("R8", "invalid pulse", 32'(cmd_invalid), 1);
        step(1);
        chk_eq("R8", "invalid clears", 32'(cmd_invalid), 0);

        // R7: fault store with selection values 1 and 3
        for (int k = 0; k < 2; k++) begin
            logic [7:0] ctl;
            ctl = (k == 0) ? 8'hA1 : 8'h07;
            tb_rf_write(8'h47, ctl);
            send_byte(1'b1, 8'h97);
            chk_eq("R7", "busy", 32'(busy), 1);
            chk_eq("R7", "req early", 32'(fault_req), 0);
            step(1);
            chk_eq("R7", "req", 32'(fault_req), 1);
            chk_eq("R7", "sel", 32'(fault_sel), 32'(ctl[1:0]));
            step(3);
            chk_eq("R7", "req held", 32'(fault_req), 1);
            send_byte(1'b1, 8'h9A);
            chk_eq("R9", "reject fault", 32'(cmd_reject), 1);
            chk_eq("R9", "page fault", 32'(page_sel), 0);
            send_byte(1'b1, 8'hFF);
            chk_eq("R9", "no invalid", 32'(cmd_invalid), 0);
            chk_eq("R9", "reject", 32'(cmd_reject), 1);
            fault_done = 1'b1;
            step(1);
            fault_done = 1'b0;
            chk_eq("R7", "req drops", 32'(fault_req), 0);
            chk_eq("R7", "busy drops", 32'(busy), 0);
        end

        // Sweep: every code from the extended page (R4, R5, R6, R8)
        exp_xfer = 2'd0;
        for (int c = 0; c < 256; c++) begin
            send_byte(1'b1, 8'h98);
            chk_eq("R4", "ext on", 32'(page_sel), 1);
            exp_page = 2'd1;
            if (c == 8'h96) ee_seed = 8'h3C;
            send_byte(1'b1, 8'(c));
            case (c)
                8'h94: exp_xfer = 2'd1;
                8'h95: exp_xfer = 2'd2;
                8'h96: begin exp_xfer = 2'd0; exp_page = 2'd0; end
                8'h98: exp_page = 2'd1;
                8'h99, 8'h9B: exp_page = 2'd0;
                8'h9A: exp_page = 2'd2;
                default: ;
            endcase
            chk_eq((c >= 8'h94 && c <= 8'h9B) ? "R4" : "R8", $sformatf("page after %0h", c),
                   32'(page_sel), 32'(exp_page));
            chk_eq("R5", $sformatf("xfer after %0h", c), 32'(xfer_mode), 32'(exp_xfer));
            chk_eq("R8", $sformatf("invalid after %0h", c), 32'(cmd_invalid),
                   (c < 8'h94 || c > 8'h9B) ? 1 : 0);
            chk_eq("R9", $sformatf("reject after %0h", c), 32'(cmd_reject), 0);
            if (c == 8'h96) begin
                chk_eq("R6", "busy", 32'(busy), 1);
                wait_idle(n);
                chk_eq("R6", "reboot edges", 32'(n + 1), 32'(1 + 5 * N_COPY));
                verify_copy("R6");
            end else if (c == 8'h97) begin
                step(1);
                chk_eq("R7", "sweep req", 32'(fault_req), 1);
                fault_done = 1'b1;
                step(1);
                fault_done = 1'b0;
                chk_eq("R11", "idle after store", 32'(busy), 0);
            end else begin
                chk_eq("R11", $sformatf("no busy after %0h", c), 32'(busy), 0);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule